// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block drives a single analog-to-digital conversion core on behalf of software. It holds the scan settings (mode, highest channel, interrupt enable), a self-clearing start bit and an end-of-conversion flag. It keeps the converter busy through a level request and a one-cycle done pulse. Each result is routed into one of four data registers, chosen by the channel's position within its group.

The eight inputs form two groups of four. In single mode the block converts only the selected channel. In multi mode it walks from the first channel of the selected group up to the selected channel, with no gap between conversions. A control write always carries the start bit. Writing it as 1 loads the new settings and starts a fresh scan at once. Writing it as 0 stops the scan and discards the conversion in flight.

Top module: `adc_scan_seq`

## Requirements
- R1: A channel code is 3 bits. Bit 2 selects the group (inputs 0..3 or 4..7), and bits 1:0 select the data register slot that receives that channel's result.
- R2: In multi mode a scan requests channels in ascending order, from 4*group up to the selected channel inclusive. It always begins at the group's first channel.
- R3: When a conversion other than the last one finishes, `convReq` stays high and `convCh` advances by one on the next cycle.
- R4: The cycle after the last conversion of a scan finishes, `startBit` and `convReq` are low.
- R5: The cycle after a done pulse, the data register of that channel's slot holds `convResult`.
- R6: A control write with start=0 drops `convReq` on the next cycle, writes no result for the conversion in flight and does not set the end flag.
- R7: A control write with start=1 loads mode, channel and interrupt enable from that same write. It begins the scan at its first channel, even during a running scan. A done pulse in a write cycle is discarded.
- R8: In single mode, exactly one conversion of the selected channel runs, and the end flag is set after it finishes.
- R9: The end flag stays set until `flagClr` is pulsed. A clear in the same cycle as a hardware set leaves the flag set.
- R10: `irq` is high exactly while the end flag and the interrupt enable are both set.
- R11: The data registers change only on a done pulse during a scan, and hold their values while idle.
- R12: After reset, all register outputs, `convReq` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control register write strobe |
| wrStart | input | 1 | Start bit value written |
| wrMulti | input | 1 | Mode written (1 = multi) |
| wrIntEn | input | 1 | Interrupt enable written |
| wrChSel | input | 3 | Selected channel written |
| flagClr | input | 1 | Clear strobe for the end flag |
| startBit | output | 1 | Start bit (high while scanning) |
| endFlag | output | 1 | End-of-conversion flag |
| multiMode | output | 1 | Current mode |
| intEn | output | 1 | Current interrupt enable |
| chSel | output | 3 | Current selected channel |
| irq | output | 1 | Interrupt request |
| convReq | output | 1 | Conversion request to the core |
| convCh | output | 3 | Channel being converted |
| convDone | input | 1 | One-cycle conversion done pulse |
| convResult | input | 10 | Result valid with convDone |
| dataRegs | output | 40 | Four result slots, slot i at bits 10*i+9..10*i |

## Verification
A wrong channel counter shows one cycle after a done pulse. `convCh` leaves the expected sequence, and the result lands in the wrong slot of `dataRegs`. A busy state that fails to clear or to drop keeps `convReq` and `startBit` high, or low, one cycle after the last done pulse or the stop write. A lost or stuck end flag is seen on `endFlag` and `irq` in the cycle after the set or clear. The reference model is compared every cycle, so any such error is reported within one clock of its cause.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef struct packed {
    logic cfgLoad;
    logic chInit;
    logic chStep;
    logic resWrite;
  } scan_strb_t;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic       wrStart,
  input  logic       flagClr,
  input  logic       convDone,
  input  logic       lastCh,
  output logic       busy,
  output logic       endFlag,
  output scan_strb_t strb
);
  logic finish;

  // a conversion only counts when no control write competes with it
  assign finish = !ctrlWr && busy && convDone;

  always_comb begin
    strb          = '0;
    strb.cfgLoad  = ctrlWr;
    strb.chInit   = ctrlWr && wrStart;
    strb.resWrite = finish;
    strb.chStep   = finish && !lastCh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      endFlag <= 1'b0;
    end else begin
      if (ctrlWr)
        busy <= wrStart;
      else if (finish && lastCh)
        busy <= 1'b0;
      // hardware set wins over a software clear
      if (finish && lastCh)
        endFlag <= 1'b1;
      else if (flagClr)
        endFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int GRP_CH  = 4,
  parameter int NUM_GRP = 2,
  localparam int CH_W   = $clog2(GRP_CH * NUM_GRP),
  localparam int IDX_W  = $clog2(GRP_CH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  scan_strb_t              strb,
  input  logic                    wrMulti,
  input  logic                    wrIntEn,
  input  logic [CH_W-1:0]         wrChSel,
  input  logic [RES_W-1:0]        convResult,
  output logic [CH_W-1:0]         curCh,
  output logic                    lastCh,
  output logic                    multiMode,
  output logic                    intEn,
  output logic [CH_W-1:0]         chSel,
  output logic [GRP_CH*RES_W-1:0] dataRegs
);
  logic [CH_W-1:0] firstCh;

  // multi mode begins at the lowest channel of the group holding wrChSel
  assign firstCh = wrMulti ? {wrChSel[CH_W-1:IDX_W], {IDX_W{1'b0}}} : wrChSel;
  assign lastCh  = (curCh == chSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      multiMode <= 1'b0;
      intEn     <= 1'b0;
      chSel     <= '0;
      curCh     <= '0;
    end else begin
      if (strb.cfgLoad) begin
        multiMode <= wrMulti;
        intEn     <= wrIntEn;
        chSel     <= wrChSel;
      end
      if (strb.chInit)
        curCh <= firstCh;
      else if (strb.chStep)
        curCh <= curCh + 1'b1;
    end
  end

  for (genvar g = 0; g < GRP_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)
        dataRegs[g*RES_W +: RES_W] <= '0;
      else if (strb.resWrite && (curCh[IDX_W-1:0] == IDX_W'(g)))
        dataRegs[g*RES_W +: RES_W] <= convResult;
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int GRP_CH  = 4,
  parameter int NUM_GRP = 2,
  localparam int CH_W   = $clog2(GRP_CH * NUM_GRP)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ctrlWr,
  input  logic                    wrStart,
  input  logic                    wrMulti,
  input  logic                    wrIntEn,
  input  logic [CH_W-1:0]         wrChSel,
  input  logic                    flagClr,
  output logic                    startBit,
  output logic                    endFlag,
  output logic                    multiMode,
  output logic                    intEn,
  output logic [CH_W-1:0]         chSel,
  output logic                    irq,
  output logic                    convReq,
  output logic [CH_W-1:0]         convCh,
  input  logic                    convDone,
  input  logic [RES_W-1:0]        convResult,
  output logic [GRP_CH*RES_W-1:0] dataRegs
);
  scan_strb_t strb;
  logic       busy;
  logic       lastCh;

  adc_scan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .wrStart(wrStart),
    .flagClr(flagClr), .convDone(convDone), .lastCh(lastCh),
    .busy(busy), .endFlag(endFlag), .strb(strb)
  );

  adc_scan_dp #(.RES_W(RES_W), .GRP_CH(GRP_CH), .NUM_GRP(NUM_GRP)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrMulti(wrMulti),
    .wrIntEn(wrIntEn), .wrChSel(wrChSel), .convResult(convResult),
    .curCh(convCh), .lastCh(lastCh), .multiMode(multiMode),
    .intEn(intEn), .chSel(chSel), .dataRegs(dataRegs)
  );

  assign startBit = busy;
  assign convReq  = busy;
  assign irq      = endFlag && intEn;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int RES_W   = 10,
  parameter int GRP_CH  = 4,
  parameter int NUM_GRP = 2,
  localparam int CH_W   = $clog2(GRP_CH * NUM_GRP),
  localparam int IDX_W  = $clog2(GRP_CH)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    ctrlWr,
  input logic                    wrStart,
  input logic                    flagClr,
  input logic                    startBit,
  input logic                    endFlag,
  input logic                    intEn,
  input logic [CH_W-1:0]         chSel,
  input logic                    irq,
  input logic                    convReq,
  input logic [CH_W-1:0]         convCh,
  input logic                    convDone,
  input logic                    lastCh,
  input logic [GRP_CH*RES_W-1:0] dataRegs
);
  assert_stop_drops_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && !wrStart |=> !convReq);

  assert_next_channel_R3: assert property (@(posedge clk) disable iff (!rstN)
    convReq && convDone && !ctrlWr && !lastCh |=>
      convReq && (convCh == CH_W'($past(convCh) + 1'b1)));

  assert_scan_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    convReq && convDone && !ctrlWr && lastCh |=> !startBit && endFlag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    endFlag && !flagClr |=> endFlag);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |-> !irq);

  assert_channel_in_group_R2: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> (convCh <= chSel) &&
      (convCh[CH_W-1:IDX_W] == chSel[CH_W-1:IDX_W]));

  assert_regs_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(convReq && convDone) |=> $stable(dataRegs));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.RES_W(RES_W), .GRP_CH(GRP_CH), .NUM_GRP(NUM_GRP)) u_chk (.*);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int RES_W      = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 1'b0, wrStart = 1'b0, wrMulti = 1'b0, wrIntEn = 1'b0, flagClr = 1'b0;
  logic [2:0] wrChSel = '0;
  logic startBit, endFlag, multiMode, intEn, irq, convReq;
  logic [2:0] chSel, convCh;
  logic convDone = 1'b0;
  logic [RES_W-1:0] convResult = '0;
  logic [4*RES_W-1:0] dataRegs;

  int vectors = 0, miscompares = 0, cycles = 0;
  int convCnt = 0, seqNo = 1, doneCount = 0, gapCount = 0;
  bit checking = 1'b0;

  // reference model state
  bit mBusy, mEnd, mMulti, mIntEn;
  int mSel, mCh;
  int mData[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .wrStart(wrStart),
    .wrMulti(wrMulti), .wrIntEn(wrIntEn), .wrChSel(wrChSel), .flagClr(flagClr),
    .startBit(startBit), .endFlag(endFlag), .multiMode(multiMode),
    .intEn(intEn), .chSel(chSel), .irq(irq), .convReq(convReq),
    .convCh(convCh), .convDone(convDone), .convResult(convResult),
    .dataRegs(dataRegs)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    bit nEnd;
    cycles++;
    if (!rstN) begin
      mBusy = 0; mEnd = 0; mMulti = 0; mIntEn = 0; mSel = 0; mCh = 0;
      foreach (mData[i]) mData[i] = 0;
    end else begin
      nEnd = mEnd;
      if (flagClr) nEnd = 0;
      if (ctrlWr) begin
        mMulti = wrMulti; mIntEn = wrIntEn; mSel = wrChSel; mBusy = wrStart;
        if (wrStart) mCh = wrMulti ? (int'(wrChSel) / 4) * 4 : int'(wrChSel);
      end else if (mBusy && convDone) begin
        mData[mCh % 4] = int'(convResult);
        doneCount++;
        if (mCh == mSel) begin mBusy = 0; nEnd = 1; end
        else mCh = mCh + 1;
      end
      mEnd = nEnd;
    end
  end

  // converter model and per-cycle comparison
  always @(negedge clk) begin
    if (checking) begin
      chk(startBit == mBusy, "R4 startBit", startBit, mBusy);
      chk(convReq == mBusy, "R6 convReq", convReq, mBusy);
      chk(endFlag == mEnd, "R9 endFlag", endFlag, mEnd);
      chk(irq == (mEnd && mIntEn), "R10 irq", irq, mEnd && mIntEn);
      chk(multiMode == mMulti && intEn == mIntEn && int'(chSel) == mSel,
          "R7 config", {multiMode, intEn, chSel}, {mMulti, mIntEn, 3'(mSel)});
      if (mBusy) chk(int'(convCh) == mCh, "R2 convCh", convCh, mCh);
      for (int i = 0; i < 4; i++)
        chk(int'(dataRegs[i*RES_W +: RES_W]) == mData[i], "R5 dataRegs",
            dataRegs[i*RES_W +: RES_W], mData[i]);
    end
    convDone = 1'b0;
    if (!convReq) convCnt = 0;
    else begin
      convCnt++;
      if (convCnt == LAT) begin
        convDone = 1'b1;
        convResult = {7'(seqNo), convCh};
        seqNo++;
        convCnt = 0;
      end
    end
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      finishRun();
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wrCtrl(input bit st, input bit mu, input bit ie, input int sel);
    ctrlWr = 1; wrStart = st; wrMulti = mu; wrIntEn = ie; wrChSel = 3'(sel);
    cyc(1);
    ctrlWr = 0;
  endtask

  task automatic clrFlag();
    flagClr = 1; cyc(1); flagClr = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200 && startBit; i++) begin
      if (!convReq) gapCount++;
      cyc(1);
    end
  endtask

  initial begin
    int snap;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R12: reset state
    chk(!startBit && !endFlag && !irq && !convReq && dataRegs == '0 && chSel == '0,
        "R12 reset", {startBit, endFlag, irq, convReq}, 0);
    checking = 1'b1;

    // R8: single mode on channel 1, exactly one conversion
    doneCount = 0;
    wrCtrl(1, 0, 1, 1);
    waitIdle(); cyc(1);
    chk(doneCount == 1, "R8 single conversions", doneCount, 1);
    chk(irq == 1'b1, "R10 irq raised", irq, 1);
    clrFlag(); cyc(1);

    // R3: multi scan of group 0 up to channel 3 without gaps
    doneCount = 0; gapCount = 0;
    wrCtrl(1, 1, 0, 3);
    waitIdle(); cyc(1);
    chk(doneCount == 4, "R2 multi group0 count", doneCount, 4);
    chk(gapCount == 0, "R3 no idle between channels", gapCount, 0);
    clrFlag();

    // R1: group 1 scan up to 6 fills slots 0..2 with channels 4..6
    doneCount = 0;
    wrCtrl(1, 1, 1, 6);
    waitIdle(); cyc(1);
    chk(doneCount == 3, "R1 group1 count", doneCount, 3);
    chk(dataRegs[2*RES_W +: 3] == 3'd6, "R1 slot2 channel", dataRegs[2*RES_W +: 3], 6);
    chk(dataRegs[0 +: 3] == 3'd4, "R1 slot0 channel", dataRegs[0 +: 3], 4);
    clrFlag();

    // R6: abort mid-scan, flag stays clear
    wrCtrl(1, 1, 1, 7);
    cyc(5);
    wrCtrl(0, 1, 1, 7);
    chk(!convReq && !endFlag, "R6 abort", {convReq, endFlag}, 0);
    cyc(6);

    // R6: abort exactly on a done pulse
    wrCtrl(1, 1, 1, 3);
    for (int i = 0; i < 20 && !convDone; i++) cyc(1);
    snap = int'(dataRegs);
    wrCtrl(0, 1, 1, 3);
    chk(int'(dataRegs) == snap && !endFlag, "R6 result dropped", dataRegs, snap);
    cyc(4);

    // R7: restart during a scan with new settings
    wrCtrl(1, 1, 0, 7);
    cyc(4);
    doneCount = 0;
    wrCtrl(1, 0, 1, 5);
    chk(convCh == 3'd5 && !multiMode, "R7 restart settings", convCh, 5);
    waitIdle(); cyc(1);
    chk(doneCount == 1, "R7 single after restart", doneCount, 1);
    clrFlag();

    // R9: software clear in the cycle the flag is set
    wrCtrl(1, 1, 1, 1);
    for (int i = 0; i < 40 && !(convDone && convCh == chSel); i++) cyc(1);
    clrFlag();
    chk(endFlag == 1'b1, "R9 set wins over clear", endFlag, 1);
    clrFlag();
    chk(endFlag == 1'b0, "R9 cleared", endFlag, 0);

    // R11: registers hold while idle
    snap = int'(dataRegs);
    cyc(20);
    chk(int'(dataRegs) == snap, "R11 idle hold", dataRegs, snap);

    // R4: start bit cleared after last conversion
    wrCtrl(1, 1, 0, 5);
    waitIdle();
    chk(!startBit && !convReq, "R4 self clear", startBit, 0);
    cyc(2);
    finishRun();
  end
endmodule